// File: doc/BRIEF.md
# Two-Thread Overriding Branch Target Predictor

This block predicts the next fetch address for a front end that serves two hardware threads. Each lookup gives a thread id and a fetch address. A small, fast target buffer answers one cycle later, and its guess is placed in that thread's prediction queue straight away. A larger target buffer is read in the same cycle as the small one, but its answer is held for a configurable number of cycles. If the queued guess is still waiting when that late answer arrives, and the large buffer hit, the late answer replaces the guess. If fetch has already taken the guess, the late answer is thrown away. When neither buffer holds the address, the guess is the next sequential fetch block.

Fetch removes predictions through a dequeue port, one thread per cycle, and gets a registered target together with a code that says which source produced it. Resolved taken branches are written into both buffers of their own thread through an update port. A per-thread flush empties that thread's queue and cancels every lookup of that thread that is still in flight. Buffers, queues and in-flight state are kept separately for each thread, so the two threads never affect each other.

Top module: `btb_override_pred`

## Requirements
- R1: During and after reset, both queues are empty, `deq_vld` is 0 and `q_full` is 0.
- R2: A lookup sampled at edge t whose address hits the thread's first-level buffer places the stored target in the thread's queue at edge t+1. A dequeue sampled at edge t+2 or later returns that target, with `deq_src` equal to 1.
- R3: When a lookup misses in both buffers, the queued prediction is the fetch address plus 32, and `deq_src` is 0.
- R4: When the second-level buffer hits for a lookup sampled at edge t, a dequeue of that entry sampled after edge t+L2_LAT returns the second-level target, with `deq_src` equal to 2.
- R5: A dequeue sampled at or before edge t+L2_LAT returns the first-level guess. The late answer is then dropped and does not change any later entry.
- R6: An update writes its target into both buffers of its thread. Each buffer is direct-mapped: the index is taken from the address bits just above the 5 offset bits of the 32-byte block, and the bits above the index are the compared tag. The write is visible to lookups sampled at later edges, but not to a lookup sampled at the same edge.
- R7: Updates, lookups and dequeues of one thread never change what the other thread's dequeues return. Each thread's queue returns its entries in lookup order.
- R8: A flush of a thread, sampled at an edge, empties that thread's queue. It also discards that thread's pending first- and second-level results, a lookup or dequeue of that thread at the same edge, and `deq_vld` is 0 for that dequeue. The other thread is not affected.
- R9: `q_full[n]` is 1 exactly when QDEPTH lookups of thread n are accepted and not yet dequeued. A lookup for a full thread is ignored.
- R10: A dequeue on a thread whose oldest entry is not yet in the queue, or whose queue is empty, gives `deq_vld` 0 in the next cycle and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_tid | input | TID_W | Thread of the lookup |
| lk_addr | input | ADDR_W | Fetch address to predict from |
| deq_req | input | 1 | Fetch takes the oldest prediction of `deq_tid` |
| deq_tid | input | TID_W | Thread being dequeued |
| deq_vld | output | 1 | Registered: a prediction was dequeued at the last edge |
| deq_target | output | ADDR_W | Registered predicted next fetch address |
| deq_src | output | 2 | Source: 0 sequential, 1 first level, 2 second level |
| upd_valid | input | 1 | A resolved taken branch is reported |
| upd_tid | input | TID_W | Thread of the resolved branch |
| upd_addr | input | ADDR_W | Fetch address of the resolved branch |
| upd_target | input | ADDR_W | Resolved target address |
| flush | input | NTHR | Per-thread flush |
| q_full | output | NTHR | Per-thread queue full |

## Verification
The sharpest corner is the race between dequeue and the late answer. A dequeue at edge t+L2_LAT must return the first-level guess. A design that lets the overwrite win, or that compares with the wrong bound, returns source 2 one cycle too early. The bench aliases two branches onto one first-level index so the two buffers disagree, and this shows whether an override was applied, missed or landed on the wrong entry. Flushes are placed while second-level answers are still in flight: a design that does not cancel them writes stale targets into new entries. Reads and updates of the same address at one edge expose a buffer with write-first behaviour. A full queue shows whether an extra lookup overwrites a live entry.

// File: rtl/btbp_pkg.sv
package btbp_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_L1  = 2'd1,
    SRC_L2  = 2'd2
  } src_e;
endpackage

// File: rtl/tgt_table.sv
// Direct-mapped target buffer with synchronous, read-first access.
module tgt_table #(
  parameter int ENTRIES = 16,
  parameter int LINE_W  = 27,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [ADDR_W-1:0] wr_tgt,
  output logic              hit,
  output logic [ADDR_W-1:0] tgt
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = LINE_W - IW;

  logic [TW-1:0]     tag_mem [ENTRIES];
  logic [ADDR_W-1:0] tgt_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  logic [IW-1:0] ridx, widx;
  logic [TW-1:0] rtag, wtag;
  logic [TW-1:0] tag_q, want_q;
  logic          vld_q;

  assign ridx = rd_line[IW-1:0];
  assign rtag = rd_line[LINE_W-1:IW];
  assign widx = wr_line[IW-1:0];
  assign wtag = wr_line[LINE_W-1:IW];

  // storage: no reset, so it can map to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[widx] <= wtag;
      tgt_mem[widx] <= wr_tgt;
    end
    tag_q  <= tag_mem[ridx];
    tgt    <= tgt_mem[ridx];
    want_q <= rtag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (wr_en) vld[widx] <= 1'b1;
      vld_q <= vld[ridx];
    end
  end

  assign hit = vld_q && (tag_q == want_q);
endmodule

// File: rtl/pred_queue.sv
// Per-thread prediction queue; entries are slotted by sequence tag.
module pred_queue
  import btbp_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int ADDR_W = 32,
  parameter int SEQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc,
  output logic [SEQ_W-1:0]  alloc_seq,
  output logic              full,
  input  logic              push,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [ADDR_W-1:0] push_tgt,
  input  src_e              push_src,
  input  logic              ovr,
  input  logic [SEQ_W-1:0]  ovr_seq,
  input  logic [ADDR_W-1:0] ovr_tgt,
  input  logic              pop_req,
  output logic              head_ok,
  output logic [ADDR_W-1:0] head_tgt,
  output src_e              head_src
);
  localparam int IW = $clog2(QDEPTH);
  localparam int CW = IW + 1;

  logic [QDEPTH-1:0] ent_v;
  logic [SEQ_W-1:0]  ent_seq [QDEPTH];
  logic [ADDR_W-1:0] ent_tgt [QDEPTH];
  src_e              ent_src [QDEPTH];

  logic [SEQ_W-1:0] head_ctr, alloc_ctr;
  logic [CW-1:0]    count;
  logic [IW-1:0]    head_idx, push_idx, ovr_idx;
  logic             pop, ovr_hit;

  assign head_idx = head_ctr[IW-1:0];
  assign push_idx = push_seq[IW-1:0];
  assign ovr_idx  = ovr_seq[IW-1:0];
  assign head_ok  = ent_v[head_idx];
  assign head_tgt = ent_tgt[head_idx];
  assign head_src = ent_src[head_idx];
  assign pop      = pop_req && head_ok && !flush;
  // the late answer only lands on an entry still waiting and not leaving now
  assign ovr_hit  = ovr && !flush && ent_v[ovr_idx] && (ent_seq[ovr_idx] == ovr_seq)
                    && !(pop && (ovr_idx == head_idx));
  assign alloc_seq = alloc_ctr;
  assign full      = (count == CW'(QDEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v     <= '0;
      head_ctr  <= '0;
      alloc_ctr <= '0;
      count     <= '0;
    end else if (flush) begin
      ent_v    <= '0;
      count    <= '0;
      head_ctr <= alloc_ctr;
    end else begin
      alloc_ctr <= alloc_ctr + SEQ_W'(alloc);
      head_ctr  <= head_ctr + SEQ_W'(pop);
      count     <= count + CW'(alloc) - CW'(pop);
      if (push) ent_v[push_idx] <= 1'b1;
      if (pop)  ent_v[head_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      ent_seq[push_idx] <= push_seq;
      ent_tgt[push_idx] <= push_tgt;
      ent_src[push_idx] <= push_src;
    end
    if (ovr_hit) begin
      ent_tgt[ovr_idx] <= ovr_tgt;
      ent_src[ovr_idx] <= SRC_L2;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(QDEPTH));

  p_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (full && !pop && !flush) |=> full);

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0) && !head_ok);
endmodule

// File: rtl/btb_override_pred.sv
module btb_override_pred
  import btbp_pkg::*;
#(
  parameter int NTHR        = 2,
  parameter int ADDR_W      = 32,
  parameter int L1_ENTRIES  = 16,
  parameter int L2_ENTRIES  = 64,
  parameter int L2_LAT      = 3,
  parameter int QDEPTH      = 4,
  parameter int FETCH_BYTES = 32,
  localparam int TID_W      = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [TID_W-1:0]  lk_tid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              deq_req,
  input  logic [TID_W-1:0]  deq_tid,
  output logic              deq_vld,
  output logic [ADDR_W-1:0] deq_target,
  output logic [1:0]        deq_src,
  input  logic              upd_valid,
  input  logic [TID_W-1:0]  upd_tid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [NTHR-1:0]   flush,
  output logic [NTHR-1:0]   q_full
);
  localparam int OFF_W  = $clog2(FETCH_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int SEQ_W  = $clog2(QDEPTH) + 2;
  localparam int STG    = L2_LAT - 1;   // delay stages after the L2 read

  // lookup acceptance
  logic              lk_acc;
  logic [SEQ_W-1:0]  th_seq [NTHR];
  assign lk_acc = lk_valid && !q_full[lk_tid] && !flush[lk_tid];

  // stage 1: buffers have been read
  logic              s1_v;
  logic [TID_W-1:0]  s1_tid;
  logic [SEQ_W-1:0]  s1_seq;
  logic [ADDR_W-1:0] s1_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= lk_acc;
    end
    s1_tid  <= lk_tid;
    s1_seq  <= th_seq[lk_tid];
    s1_addr <= lk_addr;
  end

  logic              l1_hit [NTHR];
  logic [ADDR_W-1:0] l1_tgt [NTHR];
  logic              l2_hit [NTHR];
  logic [ADDR_W-1:0] l2_tgt [NTHR];

  // second-level answer delay line
  logic              d_v   [STG];
  logic [TID_W-1:0]  d_tid [STG];
  logic [SEQ_W-1:0]  d_seq [STG];
  logic              d_hit [STG];
  logic [ADDR_W-1:0] d_tgt [STG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STG; k++) d_v[k] <= 1'b0;
    end else begin
      d_v[0] <= s1_v && !flush[s1_tid];
      for (int k = 1; k < STG; k++) d_v[k] <= d_v[k-1] && !flush[d_tid[k-1]];
    end
    d_tid[0] <= s1_tid;
    d_seq[0] <= s1_seq;
    d_hit[0] <= l2_hit[s1_tid];
    d_tgt[0] <= l2_tgt[s1_tid];
    for (int k = 1; k < STG; k++) begin
      d_tid[k] <= d_tid[k-1];
      d_seq[k] <= d_seq[k-1];
      d_hit[k] <= d_hit[k-1];
      d_tgt[k] <= d_tgt[k-1];
    end
  end

  logic              hd_ok  [NTHR];
  logic [ADDR_W-1:0] hd_tgt [NTHR];
  src_e              hd_src [NTHR];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic              wr_me, push_me, ovr_me;
    logic [ADDR_W-1:0] guess;
    src_e              guess_src;

    assign wr_me   = upd_valid && (upd_tid == TID_W'(t));
    assign push_me = s1_v && (s1_tid == TID_W'(t));
    assign ovr_me  = d_v[STG-1] && d_hit[STG-1] && (d_tid[STG-1] == TID_W'(t));
    assign guess     = l1_hit[t] ? l1_tgt[t] : (s1_addr + ADDR_W'(FETCH_BYTES));
    assign guess_src = l1_hit[t] ? SRC_L1 : SRC_SEQ;

    tgt_table #(.ENTRIES(L1_ENTRIES), .LINE_W(LINE_W), .ADDR_W(ADDR_W)) u_l1 (
      .clk(clk), .rst(rst),
      .rd_line(lk_addr[ADDR_W-1:OFF_W]),
      .wr_en(wr_me), .wr_line(upd_addr[ADDR_W-1:OFF_W]), .wr_tgt(upd_target),
      .hit(l1_hit[t]), .tgt(l1_tgt[t]));

    tgt_table #(.ENTRIES(L2_ENTRIES), .LINE_W(LINE_W), .ADDR_W(ADDR_W)) u_l2 (
      .clk(clk), .rst(rst),
      .rd_line(lk_addr[ADDR_W-1:OFF_W]),
      .wr_en(wr_me), .wr_line(upd_addr[ADDR_W-1:OFF_W]), .wr_tgt(upd_target),
      .hit(l2_hit[t]), .tgt(l2_tgt[t]));

    pred_queue #(.QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_q (
      .clk(clk), .rst(rst), .flush(flush[t]),
      .alloc(lk_acc && (lk_tid == TID_W'(t))),
      .alloc_seq(th_seq[t]), .full(q_full[t]),
      .push(push_me), .push_seq(s1_seq), .push_tgt(guess), .push_src(guess_src),
      .ovr(ovr_me), .ovr_seq(d_seq[STG-1]), .ovr_tgt(d_tgt[STG-1]),
      .pop_req(deq_req && (deq_tid == TID_W'(t))),
      .head_ok(hd_ok[t]), .head_tgt(hd_tgt[t]), .head_src(hd_src[t]));
  end

  // registered dequeue result
  always_ff @(posedge clk) begin
    if (rst) begin
      deq_vld <= 1'b0;
    end else begin
      deq_vld <= deq_req && hd_ok[deq_tid] && !flush[deq_tid];
    end
    deq_target <= hd_tgt[deq_tid];
    deq_src    <= hd_src[deq_tid];
  end

  p_deq_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
    deq_vld |-> $past(deq_req));

  p_src_legal_r2: assert property (@(posedge clk) disable iff (rst)
    deq_vld |-> (deq_src != 2'd3));
endmodule

// File: tb/btb_override_pred_test.sv
module btb_override_pred_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2, AW = 32, L1N = 16, L2N = 64, LAT = 3, QD = 4, OFFB = 5, FB = 32;

  logic clk = 1'b0, rst;
  logic lk_valid, deq_req, upd_valid, deq_vld;
  logic [0:0] lk_tid, deq_tid, upd_tid;
  logic [AW-1:0] lk_addr, upd_addr, upd_target, deq_target;
  logic [1:0] deq_src;
  logic [NT-1:0] flush, q_full;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_override_pred #(.NTHR(NT), .ADDR_W(AW), .L1_ENTRIES(L1N), .L2_ENTRIES(L2N),
    .L2_LAT(LAT), .QDEPTH(QD), .FETCH_BYTES(FB)) uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_tid(lk_tid), .lk_addr(lk_addr),
    .deq_req(deq_req), .deq_tid(deq_tid), .deq_vld(deq_vld), .deq_target(deq_target),
    .deq_src(deq_src), .upd_valid(upd_valid), .upd_tid(upd_tid), .upd_addr(upd_addr),
    .upd_target(upd_target), .flush(flush), .q_full(q_full));

  // reference model state
  bit m1v [NT][L1N]; logic [AW-1:0] m1tag [NT][L1N]; logic [AW-1:0] m1tgt [NT][L1N];
  bit m2v [NT][L2N]; logic [AW-1:0] m2tag [NT][L2N]; logic [AW-1:0] m2tgt [NT][L2N];
  int qt [NT][QD]; logic [AW-1:0] qg [NT][QD]; logic [AW-1:0] q2 [NT][QD];
  bit q2h [NT][QD]; int qs [NT][QD];
  int qh [NT]; int qc [NT];
  int ed = 0, errs = 0, checks = 0;
  bit done = 0;
  string note = "";

  task automatic chk(bit ok, string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit lv, int lt, logic [AW-1:0] la, bit dr, int dt,
                     bit uv, int ut, logic [AW-1:0] ua, logic [AW-1:0] utg, bit [1:0] fl);
    bit ev = 0; logic [AW-1:0] et = '0; int es = 0; bit fpre [NT]; string tg;
    lk_valid = lv; lk_tid = lt[0]; lk_addr = la;
    deq_req = dr; deq_tid = dt[0];
    upd_valid = uv; upd_tid = ut[0]; upd_addr = ua; upd_target = utg;
    flush = fl;
    for (int th = 0; th < NT; th++) fpre[th] = (qc[th] == QD);
    if (dr && !fl[dt] && qc[dt] > 0) begin
      int h = qh[dt];
      if (ed >= qt[dt][h] + 2) begin
        ev = 1;
        if (q2h[dt][h] && ed > qt[dt][h] + LAT) begin et = q2[dt][h]; es = 2; end
        else begin et = qg[dt][h]; es = qs[dt][h]; end
        qh[dt] = (h + 1) % QD; qc[dt]--;
      end
    end
    for (int th = 0; th < NT; th++) if (fl[th]) qc[th] = 0;
    if (lv && !fl[lt] && !fpre[lt]) begin
      logic [AW-1:0] ln = la >> OFFB;
      int i1 = int'(ln % L1N), i2 = int'(ln % L2N);
      int s = (qh[lt] + qc[lt]) % QD;
      bit h1 = m1v[lt][i1] && m1tag[lt][i1] == ln / L1N;
      qt[lt][s] = ed;
      qg[lt][s] = h1 ? m1tgt[lt][i1] : la + FB;
      qs[lt][s] = h1 ? 1 : 0;
      q2h[lt][s] = m2v[lt][i2] && m2tag[lt][i2] == ln / L2N;
      q2[lt][s] = m2tgt[lt][i2];
      qc[lt]++;
    end
    if (uv) begin
      logic [AW-1:0] ln = ua >> OFFB;
      int i1 = int'(ln % L1N), i2 = int'(ln % L2N);
      m1v[ut][i1] = 1; m1tag[ut][i1] = ln / L1N; m1tgt[ut][i1] = utg;
      m2v[ut][i2] = 1; m2tag[ut][i2] = ln / L2N; m2tgt[ut][i2] = utg;
    end
    @(posedge clk);
    @(negedge clk);
    ed++;
    tg = ev ? (es == 2 ? "R4" : (es == 1 ? "R2" : "R3")) : "R10";
    tg = {tg, note};
    chk(deq_vld == ev, tg, "deq_vld", AW'(deq_vld), AW'(ev));
    if (ev) begin
      chk(deq_target == et, tg, "deq_target", deq_target, et);
      chk(deq_src == es[1:0], tg, "deq_src", AW'(deq_src), AW'(es));
    end
    for (int th = 0; th < NT; th++)
      chk(q_full[th] == (qc[th] == QD), {"R9", note}, "q_full", AW'(q_full[th]), AW'(qc[th] == QD));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 0, 0, 0, '0, '0, 2'b00);
  endtask
  task automatic look(int t, logic [AW-1:0] a);
    cyc(1, t, a, 0, 0, 0, 0, '0, '0, 2'b00);
  endtask
  task automatic pop(int t);
    cyc(0, 0, '0, 1, t, 0, 0, '0, '0, 2'b00);
  endtask
  task automatic upd(int t, logic [AW-1:0] a, logic [AW-1:0] g);
    cyc(0, 0, '0, 0, 0, 1, t, a, g, 2'b00);
  endtask

  localparam logic [AW-1:0] A  = 32'h0000_1000;
  localparam logic [AW-1:0] A2 = 32'h0000_1200; // same L1 index as A, other L2 index
  localparam logic [AW-1:0] B  = 32'h0000_3000;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int t = 0; t < NT; t++) begin qh[t] = 0; qc[t] = 0; end
    rst = 1; lk_valid = 0; lk_tid = 0; lk_addr = 0; deq_req = 0; deq_tid = 0;
    upd_valid = 0; upd_tid = 0; upd_addr = 0; upd_target = 0; flush = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(deq_vld == 0, "R1", "deq_vld in reset", AW'(deq_vld), '0);
    rst = 0;
    @(negedge clk);
    chk(deq_vld == 0, "R1", "deq_vld after reset", AW'(deq_vld), '0);
    chk(q_full == 0, "R1", "q_full after reset", AW'(q_full), '0);

    note = "/R6";
    upd(0, A, 32'hAAAA_0000);
    upd(0, A2, 32'hBBBB_0000);          // evicts A from L1 only
    note = "/R2";
    look(0, A2); idle(1); pop(0);       // first-level hit
    note = "/R4";
    look(0, A); idle(3); pop(0);        // late answer overrides
    note = "/R5";
    look(0, A); idle(1); pop(0);        // taken before override
    look(0, A); idle(2); pop(0);        // same edge as override
    look(0, A); idle(3); pop(0);        // next entry unaffected
    note = "/R7";
    upd(1, A2, 32'hCCCC_0000);
    look(1, A2); look(0, A2); look(1, A); idle(1);
    pop(1); pop(0); pop(1);
    note = "/R6";
    cyc(1, 0, B, 0, 0, 1, 0, B, 32'hDDDD_0000, 2'b00); // same-edge update
    idle(3); pop(0);
    look(0, B); idle(3); pop(0);
    note = "/R8";
    look(0, A); look(1, A2); look(0, A);
    cyc(1, 0, A2, 0, 0, 0, 0, '0, '0, 2'b01);
    idle(4); pop(0); pop(1);
    look(0, A); idle(1);
    cyc(0, 0, '0, 1, 0, 0, 0, '0, '0, 2'b01); // dequeue loses to flush
    pop(0);
    note = "/R9";
    for (int i = 0; i < 5; i++) look(1, 32'h5000 + i * 32);
    idle(3);
    for (int i = 0; i < 5; i++) pop(1);
    note = "/R10";
    pop(0);
    look(0, A); pop(0); idle(2); pop(0);

    note = "";
    for (int i = 0; i < 4000; i++) begin
      bit [1:0] fl = 2'b00;
      if ($urandom % 100 < 3) fl = 2'b01 << ($urandom % 2);
      cyc(($urandom % 2) == 0, int'($urandom % 2), AW'(($urandom % 96) << OFFB),
          ($urandom % 10) < 6, int'($urandom % 2),
          ($urandom % 10) < 3, int'($urandom % 2), AW'(($urandom % 96) << OFFB),
          AW'($urandom), fl);
    end
    idle(4);
    for (int i = 0; i < 2 * QD; i++) pop(i % 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule